// File: doc/BRIEF.md
# Link Response Error Checker

This block sits on the receive side of a packetized serial memory link, after deserialization, CRC evaluation and lane alignment. Each cycle it may be offered one response packet, summarized by its header and tail fields: command, tag, length and duplicate length, sequence number, the CRC verdict computed upstream, the response status and the cube ID. It checks the packet's integrity, tracks the expected sequence number, and decides what to do with the response.

A packet that fails the length, CRC or sequence check is dropped and sets a sticky interrupt bit for each check it failed. A packet that passes is forwarded to the application one cycle later, together with a flag that is raised when its status is non-zero. The one exception is an error-type response with a non-zero status. It is not forwarded. Its status and cube ID go into a small queue instead, and software reads the oldest entry through the head outputs and retires it with a pop strobe. Saturating counters keep a count of packets in each error category.

Top module: `rsp_err_chk`

## Requirements
- R1: A valid packet whose length field differs from its duplicate length field, or whose length field is 0 or above 9, is not forwarded. It sets `irq_status[0]` and increments `cnt_len`.
- R2: A valid packet with `in_crc_ok` low is not forwarded. It sets `irq_status[1]` and increments `cnt_crc`.
- R3: The expected sequence number is 0 after reset. It advances by one (mod 8) for each valid packet that passes all three checks. A valid packet whose `in_seq` differs from it is not forwarded, sets `irq_status[2]` and increments `cnt_seq`.
- R4: A packet that passes all checks and is not diverted appears on `out_valid`, `out_cmd` and `out_tag` in the cycle after it is presented. If its status is zero, `out_rsp_error` is 0.
- R5: A forwarded packet with a non-zero status (read 0x38, write 0x39, mode 0x3A/0x3B, or any other non-error command) has `out_rsp_error` set to 1. Every passing packet with a non-zero status increments `cnt_stat`, whether it is forwarded or diverted.
- R6: A passing error response (command 0x3E) with a non-zero status is not forwarded, and its {status, cube ID} is queued. An error response with a zero status is forwarded with `out_rsp_error` set to 0.
- R7: `erq_valid`, `erq_status` and `erq_cube` show the oldest queued entry, in arrival order. `erq_pop` retires the head while the queue is non-empty. Back-to-back entries are all kept while space remains, and a push and a pop in the same cycle are both honoured.
- R8: An error response that arrives while the queue holds FIFO_DEPTH entries, with no pop in that cycle, is discarded and sets `irq_status[3]`.
- R9: Interrupt bits are sticky. A 1 in `irq_clear` clears the matching bit, and a new event in the same cycle wins over the clear.
- R10: Every counter stops at its all-ones value instead of wrapping.
- R11: After reset, `out_valid`, `erq_valid`, `irq_status` and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A response packet is presented this cycle |
| in_cmd | input | 6 | Response command code |
| in_tag | input | TAG_W | Request tag |
| in_lng | input | 5 | Length field |
| in_dln | input | 5 | Duplicate length field |
| in_seq | input | 3 | Sequence field |
| in_crc_ok | input | 1 | Upstream CRC verdict, 1 = correct |
| in_errstat | input | 7 | Response status |
| in_cube | input | 3 | Cube ID |
| out_valid | output | 1 | Forwarded response valid |
| out_cmd | output | 6 | Forwarded command |
| out_tag | output | TAG_W | Forwarded tag |
| out_rsp_error | output | 1 | Forwarded response has a non-zero status |
| erq_valid | output | 1 | Error queue is not empty |
| erq_status | output | 7 | Status of the oldest queued entry |
| erq_cube | output | 3 | Cube ID of the oldest queued entry |
| erq_pop | input | 1 | Retire the head entry |
| irq_status | output | 4 | Sticky bits: 0 length, 1 CRC, 2 sequence, 3 queue overflow |
| irq_clear | input | 4 | Write-one-to-clear strobes for irq_status |
| cnt_len | output | CNT_W | Length error count |
| cnt_crc | output | CNT_W | CRC error count |
| cnt_seq | output | CNT_W | Sequence error count |
| cnt_stat | output | CNT_W | Count of passing packets with a non-zero status |

## Verification
The bench builds the block with CNT_W = 4 and FIFO_DEPTH = 4. With 4-bit counters, a burst of about twenty CRC failures drives a counter to its ceiling, so saturation is checked directly rather than left out of reach as it would be at 32 bits. A depth of four lets five back-to-back error responses fill the queue and overflow it, and popping the queue afterwards shows that the entries come out in arrival order. A long random run then mixes wrong sequence numbers, bad lengths, pops and clears.

// File: rtl/rsp_err_pkg.sv
package rsp_err_pkg;
  localparam int CMD_W  = 6;
  localparam int LNG_W  = 5;
  localparam int SEQ_W  = 3;
  localparam int STAT_W = 7;
  localparam int CUB_W  = 3;
  localparam int LNG_MAX = 9;
  localparam int N_CAT   = 4;

  localparam logic [CMD_W-1:0] CMD_RD_RSP  = 6'h38;
  localparam logic [CMD_W-1:0] CMD_WR_RSP  = 6'h39;
  localparam logic [CMD_W-1:0] CMD_MRD_RSP = 6'h3A;
  localparam logic [CMD_W-1:0] CMD_MWR_RSP = 6'h3B;
  localparam logic [CMD_W-1:0] CMD_ERR_RSP = 6'h3E;

  localparam int IRQ_LEN = 0;
  localparam int IRQ_CRC = 1;
  localparam int IRQ_SEQ = 2;
  localparam int IRQ_OVF = 3;

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic [CUB_W-1:0]  cube;
  } erq_entry_t;
endpackage

// File: rtl/rsp_classify.sv
module rsp_classify
  import rsp_err_pkg::*;
(
  input  logic [CMD_W-1:0]  cmd,
  input  logic [LNG_W-1:0]  lng,
  input  logic [LNG_W-1:0]  dln,
  input  logic [SEQ_W-1:0]  seq,
  input  logic [SEQ_W-1:0]  exp_seq,
  input  logic              crc_ok,
  input  logic [STAT_W-1:0] stat,
  output logic              len_bad,
  output logic              crc_bad,
  output logic              seq_bad,
  output logic              pass,
  output logic              divert,
  output logic              flag
);
  always_comb begin
    len_bad = (lng != dln) || (lng == '0) || (lng > LNG_W'(LNG_MAX));
    crc_bad = !crc_ok;
    seq_bad = (seq != exp_seq);
    pass    = !(len_bad || crc_bad || seq_bad);
    flag    = (stat != '0);
    divert  = (cmd == CMD_ERR_RSP) && flag;
  end
endmodule

// File: rtl/rsp_sat_cnt.sv
module rsp_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (inc && !(&q)) q_n = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  // R10: the ceiling is held
  assert_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&q) |=> (&q));
endmodule

// File: rtl/rsp_err_fifo.sv
module rsp_err_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         head_vld,
  output logic [W-1:0] head,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop, full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full    = (cnt_q == CW'(DEPTH));
    do_pop  = pop && (cnt_q != '0);
    do_push = push && (!full || do_pop);
    ovf     = push && !do_push;
    mem_n   = mem_q;
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    if (do_push) begin
      mem_n[wr_q] = din;
      wr_n        = nxt(wr_q);
    end
    if (do_pop) rd_n = nxt(rd_q);
    if (do_push && !do_pop) cnt_n = cnt_q + CW'(1);
    if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_n;
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  assign head_vld = (cnt_q != '0);
  assign head     = head_vld ? mem_q[rd_q] : '0;

  // R8: occupancy never exceeds the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7: a push into an empty queue makes the head valid
  assert_head_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !head_vld) |=> head_vld);
endmodule

// File: rtl/rsp_err_chk.sv
module rsp_err_chk
  import rsp_err_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int TAG_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [5:0]        in_cmd,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [4:0]        in_lng,
  input  logic [4:0]        in_dln,
  input  logic [2:0]        in_seq,
  input  logic              in_crc_ok,
  input  logic [6:0]        in_errstat,
  input  logic [2:0]        in_cube,
  output logic              out_valid,
  output logic [5:0]        out_cmd,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_rsp_error,
  output logic              erq_valid,
  output logic [6:0]        erq_status,
  output logic [2:0]        erq_cube,
  input  logic              erq_pop,
  output logic [3:0]        irq_status,
  input  logic [3:0]        irq_clear,
  output logic [CNT_W-1:0]  cnt_len,
  output logic [CNT_W-1:0]  cnt_crc,
  output logic [CNT_W-1:0]  cnt_seq,
  output logic [CNT_W-1:0]  cnt_stat
);
  localparam int EW = STAT_W + CUB_W;

  logic [SEQ_W-1:0] seq_q, seq_n;
  logic len_bad, crc_bad, seq_bad, pass, divert, flag;
  logic ovf, push, ov_n, fwd;
  logic [3:0] irq_q, irq_n, irq_set;
  logic [N_CAT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_q [N_CAT];
  erq_entry_t push_e, head_e;
  logic [EW-1:0] head_raw;

  rsp_classify u_cls (
    .cmd(in_cmd), .lng(in_lng), .dln(in_dln), .seq(in_seq), .exp_seq(seq_q),
    .crc_ok(in_crc_ok), .stat(in_errstat), .len_bad(len_bad), .crc_bad(crc_bad),
    .seq_bad(seq_bad), .pass(pass), .divert(divert), .flag(flag)
  );

  always_comb begin
    fwd    = in_valid && pass;
    push   = fwd && divert;
    ov_n   = fwd && !divert;
    seq_n  = fwd ? seq_q + SEQ_W'(1) : seq_q;
    push_e = '{stat: in_errstat, cube: in_cube};
    irq_set = '0;
    irq_set[IRQ_LEN] = in_valid && len_bad;
    irq_set[IRQ_CRC] = in_valid && crc_bad;
    irq_set[IRQ_SEQ] = in_valid && seq_bad;
    irq_set[IRQ_OVF] = ovf;
    irq_n   = (irq_q & ~irq_clear) | irq_set;
    cnt_inc = {fwd && flag, irq_set[IRQ_SEQ], irq_set[IRQ_CRC], irq_set[IRQ_LEN]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q         <= '0;
      irq_q         <= '0;
      out_valid     <= 1'b0;
      out_cmd       <= '0;
      out_tag       <= '0;
      out_rsp_error <= 1'b0;
    end else begin
      seq_q     <= seq_n;
      irq_q     <= irq_n;
      out_valid <= ov_n;
      if (ov_n) begin
        out_cmd       <= in_cmd;
        out_tag       <= in_tag;
        out_rsp_error <= flag;
      end
    end
  end

  rsp_err_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_e), .pop(erq_pop),
    .head_vld(erq_valid), .head(head_raw), .ovf(ovf)
  );

  assign head_e     = head_raw;
  assign erq_status = head_e.stat;
  assign erq_cube   = head_e.cube;
  assign irq_status = irq_q;

  for (genvar g = 0; g < N_CAT; g++) begin : g_cnt
    rsp_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[g]), .q(cnt_q[g])
    );
  end

  assign cnt_len  = cnt_q[0];
  assign cnt_crc  = cnt_q[1];
  assign cnt_seq  = cnt_q[2];
  assign cnt_stat = cnt_q[3];

  // R1: disagreeing length fields are never forwarded
  assert_len_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_lng != in_dln) |=> (!out_valid && irq_status[0]));
  // R2: a bad CRC is flagged and dropped
  assert_crc_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_crc_ok) |=> (!out_valid && irq_status[1]));
  // R6: error responses with a status stay off the data path
  assert_divert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cmd == CMD_ERR_RSP && in_errstat != '0) |=> !out_valid);
  // R9: with no packet offered, cleared bits read back as zero
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> ((irq_status & $past(irq_clear)) == 4'h0));
endmodule

// File: tb/rsp_err_chk_test.sv
module rsp_err_chk_test;
  localparam int CW = 4;
  localparam int DP = 4;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_crc_ok, erq_pop;
  logic [5:0] in_cmd;
  logic [TW-1:0] in_tag;
  logic [4:0] in_lng, in_dln;
  logic [2:0] in_seq, in_cube;
  logic [6:0] in_errstat;
  logic [3:0] irq_clear;
  logic out_valid, out_rsp_error, erq_valid;
  logic [5:0] out_cmd;
  logic [TW-1:0] out_tag;
  logic [6:0] erq_status;
  logic [2:0] erq_cube;
  logic [3:0] irq_status;
  logic [CW-1:0] cnt_len, cnt_crc, cnt_seq, cnt_stat;

  int total = 0;
  int bad = 0;

  // reference model state
  int m_seq, m_n, m_irq, m_ov, m_oflag, m_ocmd, m_otag;
  int m_cnt [4];
  int m_qs [DP];
  int m_qc [DP];

  always #2 clk = ~clk;

  rsp_err_chk #(.CNT_W(CW), .FIFO_DEPTH(DP), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cmd(in_cmd), .in_tag(in_tag),
    .in_lng(in_lng), .in_dln(in_dln), .in_seq(in_seq), .in_crc_ok(in_crc_ok),
    .in_errstat(in_errstat), .in_cube(in_cube), .out_valid(out_valid),
    .out_cmd(out_cmd), .out_tag(out_tag), .out_rsp_error(out_rsp_error),
    .erq_valid(erq_valid), .erq_status(erq_status), .erq_cube(erq_cube),
    .erq_pop(erq_pop), .irq_status(irq_status), .irq_clear(irq_clear),
    .cnt_len(cnt_len), .cnt_crc(cnt_crc), .cnt_seq(cnt_seq), .cnt_stat(cnt_stat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v, input bit inc);
    return (inc && v < (1 << CW) - 1) ? v + 1 : v;
  endfunction

  task automatic model_reset();
    m_seq = 0; m_n = 0; m_irq = 0; m_ov = 0; m_oflag = 0; m_ocmd = 0; m_otag = 0;
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    for (int i = 0; i < DP; i++) begin m_qs[i] = 0; m_qc[i] = 0; end
  endtask

  task automatic compare();
    chk(out_valid == m_ov[0], "R4 out_valid", int'(out_valid), m_ov);
    if (m_ov != 0) begin
      chk(out_cmd == 6'(m_ocmd) && out_tag == TW'(m_otag), "R4 cmd/tag",
          int'(out_tag), m_otag);
      chk(out_rsp_error == m_oflag[0], "R5 rsp_error", int'(out_rsp_error), m_oflag);
    end
    chk(irq_status == 4'(m_irq), "R9 irq_status", int'(irq_status), m_irq);
    chk(cnt_len == CW'(m_cnt[0]), "R1 cnt_len", int'(cnt_len), m_cnt[0]);
    chk(cnt_crc == CW'(m_cnt[1]), "R2 cnt_crc", int'(cnt_crc), m_cnt[1]);
    chk(cnt_seq == CW'(m_cnt[2]), "R3 cnt_seq", int'(cnt_seq), m_cnt[2]);
    chk(cnt_stat == CW'(m_cnt[3]), "R5 cnt_stat", int'(cnt_stat), m_cnt[3]);
    chk(erq_valid == (m_n != 0), "R7 erq_valid", int'(erq_valid), int'(m_n != 0));
    if (m_n != 0)
      chk(erq_status == 7'(m_qs[0]) && erq_cube == 3'(m_qc[0]), "R7 head status",
          int'(erq_status), m_qs[0]);
  endtask

  // drive one cycle at a falling edge, update the model, check after the rise
  task automatic step(input bit v, input int cmd, input int tag, input int lng,
                      input int dln, input int seq, input bit crc, input int st,
                      input int cub, input bit pop, input int clr);
    bit lb, cb, sb, ps, dv, dpop, dpush, ov;
    int set;
    in_valid = v; in_cmd = 6'(cmd); in_tag = TW'(tag); in_lng = 5'(lng);
    in_dln = 5'(dln); in_seq = 3'(seq); in_crc_ok = crc; in_errstat = 7'(st);
    in_cube = 3'(cub); erq_pop = pop; irq_clear = 4'(clr);
    lb = (lng != dln) || lng == 0 || lng > 9;
    cb = !crc;
    sb = (seq != m_seq);
    ps = v && !(lb || cb || sb);
    dv = (cmd == 'h3E) && st != 0;
    dpop = pop && m_n > 0;
    dpush = ps && dv && (m_n < DP || dpop);
    ov = ps && dv && !dpush;
    set = (v && lb ? 1 : 0) | (v && cb ? 2 : 0) | (v && sb ? 4 : 0) | (ov ? 8 : 0);
    m_irq = (m_irq & ~clr & 15) | set;
    m_cnt[0] = sat(m_cnt[0], v && lb);
    m_cnt[1] = sat(m_cnt[1], v && cb);
    m_cnt[2] = sat(m_cnt[2], v && sb);
    m_cnt[3] = sat(m_cnt[3], ps && st != 0);
    if (dpop) begin
      for (int i = 0; i < DP - 1; i++) begin m_qs[i] = m_qs[i+1]; m_qc[i] = m_qc[i+1]; end
      m_n--;
    end
    if (dpush) begin m_qs[m_n] = st; m_qc[m_n] = cub; m_n++; end
    m_ov = (ps && !dv) ? 1 : 0;
    if (m_ov != 0) begin m_ocmd = cmd; m_otag = tag; m_oflag = (st != 0) ? 1 : 0; end
    if (ps) m_seq = (m_seq + 1) % 8;
    @(posedge clk); #1;
    compare();
    @(negedge clk);
  endtask

  task automatic pkt(input int cmd, input int st, input int cub);
    step(1, cmd, cmd + st, 3, 3, m_seq, 1, st, cub, 0, 0);
  endtask

  task automatic idle(input bit pop, input int clr);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, pop, clr);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    rst_n = 1'b0;
    in_valid = 0; in_cmd = 0; in_tag = 0; in_lng = 0; in_dln = 0; in_seq = 0;
    in_crc_ok = 1; in_errstat = 0; in_cube = 0; erq_pop = 0; irq_clear = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!out_valid && !erq_valid && irq_status == 0 && cnt_len == 0 && cnt_crc == 0
        && cnt_seq == 0 && cnt_stat == 0, "R11 reset state", int'(irq_status), 0);
    rst_n = 1'b1;
    @(negedge clk);

    pkt('h38, 0, 0);            // R4 clean read
    pkt('h39, 5, 1);            // R5 write with status
    pkt('h3A, 9, 0);            // R5 mode with status
    pkt('h3E, 0, 4);            // R6 error response, zero status: forwarded
    pkt('h3E, 3, 2);            // R6 diverted
    chk(!out_valid && erq_status == 3 && erq_cube == 2, "R6 divert head",
        int'(erq_status), 3);
    step(1, 'h38, 1, 4, 5, m_seq, 1, 0, 0, 0, 0);    // R1 mismatch
    chk(!out_valid && irq_status[0], "R1 length mismatch", int'(irq_status), 1);
    step(1, 'h38, 1, 0, 0, m_seq, 1, 0, 0, 0, 0);    // R1 zero length
    step(1, 'h38, 1, 10, 10, m_seq, 1, 0, 0, 0, 0);  // R1 too long
    step(1, 'h38, 1, 2, 2, m_seq, 0, 0, 0, 0, 0);    // R2 crc
    chk(!out_valid && irq_status[1], "R2 crc drop", int'(irq_status), 3);
    step(1, 'h38, 1, 2, 2, (m_seq + 3) % 8, 1, 0, 0, 0, 0);  // R3 wrong seq
    chk(!out_valid && irq_status[2], "R3 seq drop", int'(irq_status), 7);
    pkt('h38, 0, 0);            // R3 expectation unchanged after the drop
    chk(out_valid, "R3 resume", int'(out_valid), 1);

    // R8: fill and overflow with back-to-back error responses
    for (int i = 0; i < 5; i++) pkt('h3E, 10 + i, i);
    chk(irq_status[3], "R8 overflow sticky", int'(irq_status), 15);
    // R7: drain in arrival order
    for (int i = 0; i < 4; i++) idle(1, 0);
    chk(!erq_valid, "R7 drained", int'(erq_valid), 0);
    // R9: clear, then set wins over clear in the same cycle
    idle(0, 15);
    chk(irq_status == 0, "R9 clear", int'(irq_status), 0);
    step(1, 'h38, 1, 2, 2, m_seq, 0, 0, 0, 0, 2);
    chk(irq_status[1], "R9 set wins", int'(irq_status), 2);
    // R10: push crc counter to the ceiling
    for (int i = 0; i < 20; i++) step(1, 'h38, 1, 2, 2, m_seq, 0, 0, 0, 0, 0);
    chk(cnt_crc == 4'hF, "R10 saturate", int'(cnt_crc), 15);
    // R7: push and pop in the same cycle on a full queue
    for (int i = 0; i < 4; i++) pkt('h3E, 20 + i, i);
    step(1, 'h3E, 0, 3, 3, m_seq, 1, 30, 5, 1, 0);
    chk(erq_status == 21, "R7 push+pop full", int'(erq_status), 21);

    s = $urandom(32'h5EED);
    for (int i = 0; i < 3000; i++) begin
      int c, l, d, q, st;
      int cmds [6] = '{'h38, 'h39, 'h3A, 'h3B, 'h3E, 'h3E};
      c = cmds[$urandom_range(5)];
      l = $urandom_range(10);
      d = ($urandom_range(9) == 0) ? $urandom_range(10) : l;
      q = ($urandom_range(7) == 0) ? $urandom_range(7) : m_seq;
      st = ($urandom_range(1) == 0) ? 0 : $urandom_range(127);
      step($urandom_range(3) != 0, c, $urandom_range(255), l, d, q,
           $urandom_range(11) != 0, st, $urandom_range(7),
           $urandom_range(2) == 0, ($urandom_range(5) == 0) ? $urandom_range(15) : 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule